// File: doc/BRIEF.md
# Hardware Write-Inhibit and Strobe Filter

This block sits between the raw control pins of a nonvolatile memory and its write controller. It issues a write request only when every hardware protection condition holds. Chip enable, output enable and write enable arrive active low. A digital supply-good flag arrives active high and stands in for an analog supply comparator. All four inputs pass through a synchronizer. The effective write strobe is the interval in which chip enable and write enable are both active.

The block qualifies each strobe against three conditions. The supply must be good. A power-up hold-off, counted in clock cycles from the synchronized rising edge of supply-good, must have elapsed. Output enable must stay inactive. In addition, the strobe must last at least a minimum number of cycles, so that glitches are rejected. An accepted strobe produces a single-cycle pulse once it ends. An `inhibit` output reports whether the supply gate or the hold-off is currently blocking writes.

The synchronizer depth S (`SYNC_STAGES`), the hold-off length H (`HOLDOFF_CYC`) and the minimum strobe width M (`MIN_PULSE_CYC`) are parameters. With S = 0 the synchronizer is left out and the inputs are used as they arrive.

Top module: `write_guard`

## Requirements
- R1: While reset is asserted and after it is released, `wr_pulse` is 0 and `inhibit` is 1 until the supply sequence below completes.
- R2: While `supply_ok` is 0, `inhibit` is 1 and no strobe produces a pulse.
- R3: When `supply_ok` is driven to 1 in cycle P, `inhibit` stays 1 through cycle P+S+H-1 and is 0 from cycle P+S+H on.
- R4: If `supply_ok` drops for even one cycle during the hold-off, the full hold-off of H cycles restarts from the next rising edge.
- R5: When `supply_ok` is driven to 0 in cycle P after the hold-off has elapsed, `inhibit` is still 0 in cycle P+S and is 1 in cycle P+S+1. A strobe during which the supply was lost in any cycle produces no pulse.
- R6: A strobe during which `oe_n` is 0 (output enable active) for even one synchronized cycle produces no pulse.
- R7: A strobe whose active overlap lasts fewer than M cycles produces no pulse. An overlap of exactly M cycles, or of any greater length, produces one pulse.
- R8: The strobe is the overlap of `ce_n` = 0 and `we_n` = 0. Either input low on its own never produces a pulse. When both are low, the strobe ends at whichever of the two rises first.
- R9: An accepted strobe whose last active input returns high in cycle P produces a pulse of exactly one cycle in cycle P+S+1.
- R10: A strobe with any cycle before the hold-off has elapsed produces no pulse, even if the strobe ends after the hold-off has elapsed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| supply_ok | input | 1 | Digital supply-good flag, 1 = above sense level |
| ce_n | input | 1 | Chip enable, active low |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write enable, active low |
| wr_pulse | output | 1 | Qualified write request, one cycle per accepted strobe |
| inhibit | output | 1 | 1 while the supply gate or the hold-off blocks writes |

## Verification
A hold-off counter that does not clear when the supply drops makes `inhibit` fall too early after the next rise. The cycle checks on `inhibit` catch this within S+H cycles. A width counter or a spoil flag that is stale or cleared too soon either lets a glitch or a blocked strobe through, or swallows a legal strobe. Either error shows as a wrong pulse count within S+1 cycles of the strobe's end. Every pulse the bench expects carries an exact target cycle, so any extra register stage on the path is caught by the first accepted strobe.

// File: rtl/wg_pkg.sv
package wg_pkg;

   // Synchronized control pins, bundled so that a single synchronizer carries them.
   typedef struct packed {
      logic supply_ok;
      logic oe_n;
      logic we_n;
      logic ce_n;
   } wg_pins_t;

   // Safe state: supply absent and all enables inactive.
   localparam wg_pins_t WG_PINS_IDLE = '{supply_ok: 1'b0, oe_n: 1'b1, we_n: 1'b1, ce_n: 1'b1};

   // Counter width needed to hold the values 0 .. lim.
   function automatic int unsigned wg_cnt_w(input int unsigned lim);
      return (lim < 2) ? 1 : $clog2(lim + 1);
   endfunction

endpackage

// File: rtl/wg_sync.sv
module wg_sync #(
   parameter int unsigned STAGES = 2,
   parameter int unsigned WIDTH  = 4,
   parameter logic [WIDTH-1:0] RST_VAL = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);

   generate
      if (STAGES == 0) begin : g_bypass
         assign q = d;
      end else begin : g_chain
         logic [WIDTH-1:0] stg [STAGES];
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               for (int i = 0; i < int'(STAGES); i++) stg[i] <= RST_VAL;
            end else begin
               stg[0] <= d;
               for (int i = 1; i < int'(STAGES); i++) stg[i] <= stg[i-1];
            end
         end
         assign q = stg[STAGES-1];
      end
   endgenerate

endmodule

// File: rtl/wg_holdoff.sv
module wg_holdoff
   import wg_pkg::*;
#(
   parameter int unsigned HOLD_CYC = 5000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic supply_s,
   output logic ready
);

   localparam int unsigned CW = wg_cnt_w(HOLD_CYC);
   localparam logic [CW-1:0] LAST = CW'(HOLD_CYC - 1);

   logic [CW-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt   <= '0;
         ready <= 1'b0;
      end else if (!supply_s) begin
         // Any loss of supply cancels progress; count again from zero.
         cnt   <= '0;
         ready <= 1'b0;
      end else if (!ready) begin
         if (cnt == LAST) ready <= 1'b1;
         else             cnt   <= cnt + 1'b1;
      end
   end

endmodule

// File: rtl/wg_strobe_qual.sv
module wg_strobe_qual
   import wg_pkg::*;
#(
   parameter int unsigned MIN_CYC = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic strb,
   input  logic ok,
   output logic pulse
);

   localparam int unsigned CW = wg_cnt_w(MIN_CYC);
   localparam logic [CW-1:0] SAT = CW'(MIN_CYC);

   logic [CW-1:0] run_len;
   logic          spoiled;
   logic          strb_d;
   logic          accept;

   // The strobe just ended, was never blocked and lasted long enough.
   assign accept = strb_d & ~strb & ~spoiled & (run_len == SAT);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run_len <= '0;
         spoiled <= 1'b0;
         strb_d  <= 1'b0;
         pulse   <= 1'b0;
      end else begin
         strb_d <= strb;
         pulse  <= accept;
         if (!strb) begin
            run_len <= '0;
            spoiled <= 1'b0;
         end else begin
            if (!ok)           spoiled <= 1'b1;
            if (run_len != SAT) run_len <= run_len + 1'b1;
         end
      end
   end

endmodule

// File: rtl/write_guard.sv
module write_guard
   import wg_pkg::*;
#(
   parameter int unsigned HOLDOFF_CYC   = 5000,
   parameter int unsigned MIN_PULSE_CYC = 2,
   parameter int unsigned SYNC_STAGES   = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic supply_ok,
   input  logic ce_n,
   input  logic oe_n,
   input  logic we_n,
   output logic wr_pulse,
   output logic inhibit
);

   localparam int unsigned PW = $bits(wg_pins_t);

   generate
      if (HOLDOFF_CYC < 1) begin : g_bad_hold
         $error("write_guard: HOLDOFF_CYC must be at least 1");
      end
      if (MIN_PULSE_CYC < 1) begin : g_bad_min
         $error("write_guard: MIN_PULSE_CYC must be at least 1");
      end
      if (SYNC_STAGES == 1) begin : g_bad_sync
         $error("write_guard: SYNC_STAGES must be 0 or at least 2");
      end
   endgenerate

   wg_pins_t raw_pins, syn_pins;
   logic     sup_s, oe_s, strb, ready, ok;

   assign raw_pins = '{supply_ok: supply_ok, oe_n: oe_n, we_n: we_n, ce_n: ce_n};

   wg_sync #(
      .STAGES  (SYNC_STAGES),
      .WIDTH   (PW),
      .RST_VAL (WG_PINS_IDLE)
   ) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (raw_pins),
      .q     (syn_pins)
   );

   assign sup_s = syn_pins.supply_ok;
   assign oe_s  = syn_pins.oe_n;
   assign strb  = ~syn_pins.ce_n & ~syn_pins.we_n;

   wg_holdoff #(.HOLD_CYC(HOLDOFF_CYC)) u_hold (
      .clk      (clk),
      .rst_n    (rst_n),
      .supply_s (sup_s),
      .ready    (ready)
   );

   assign ok = ready & oe_s;

   wg_strobe_qual #(.MIN_CYC(MIN_PULSE_CYC)) u_qual (
      .clk   (clk),
      .rst_n (rst_n),
      .strb  (strb),
      .ok    (ok),
      .pulse (wr_pulse)
   );

   assign inhibit = ~ready;

endmodule

// File: rtl/wg_checker.sv
module wg_checker
   import wg_pkg::*;
#(
   parameter int unsigned MIN_PULSE_CYC = 2
) (
   input logic clk,
   input logic rst_n,
   input logic strb,
   input logic oe_s,
   input logic sup_s,
   input logic wr_pulse,
   input logic inhibit
);

   localparam int unsigned CW = wg_cnt_w(MIN_PULSE_CYC);

   // The checker keeps its own count of the strobe's length and its own output-enable flag.
   logic [CW-1:0] len;
   logic          oe_hit;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         len    <= '0;
         oe_hit <= 1'b0;
      end else if (!strb) begin
         len    <= '0;
         oe_hit <= 1'b0;
      end else begin
         if (len != CW'(MIN_PULSE_CYC)) len <= len + 1'b1;
         if (!oe_s) oe_hit <= 1'b1;
      end
   end

   assert_single_cycle_R9: assert property (@(posedge clk) disable iff (!rst_n)
      wr_pulse |=> !wr_pulse);

   assert_after_strobe_end_R9: assert property (@(posedge clk) disable iff (!rst_n)
      wr_pulse |-> ($past(!strb) && $past(strb, 2)));

   assert_min_width_R7: assert property (@(posedge clk) disable iff (!rst_n)
      wr_pulse |-> ($past(len) == CW'(MIN_PULSE_CYC)));

   assert_oe_blocks_R6: assert property (@(posedge clk) disable iff (!rst_n)
      wr_pulse |-> !$past(oe_hit));

   assert_supply_low_inhibits_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !sup_s |=> inhibit);

   assert_holdoff_restarts_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sup_s) |-> inhibit);

   assert_ready_before_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
      wr_pulse |-> $past(!inhibit, 2));

endmodule

bind write_guard wg_checker #(.MIN_PULSE_CYC(MIN_PULSE_CYC)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .strb     (strb),
   .oe_s     (oe_s),
   .sup_s    (sup_s),
   .wr_pulse (wr_pulse),
   .inhibit  (inhibit)
);

// File: tb/sim_write_guard.sv
module sim_write_guard;

   localparam int CLK_PERIOD = 10;
   localparam int HOLD = 20;
   localparam int MINW = 3;
   localparam int SYNC = 2;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic supply_ok = 1'b0;
   logic ce_n = 1'b1;
   logic oe_n = 1'b1;
   logic we_n = 1'b1;
   logic wr_pulse, inhibit;

   int    cyc = 0;
   int    checks = 0;
   int    fails = 0;
   int    pulse_cnt = 0;
   bit    done = 1'b0;
   bit    prev_pulse = 1'b0;
   string cur_tag = "R1";
   int    exp_q[$];

   always #(CLK_PERIOD/2) clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   write_guard #(
      .HOLDOFF_CYC   (HOLD),
      .MIN_PULSE_CYC (MINW),
      .SYNC_STAGES   (SYNC)
   ) u0 (
      .clk       (clk),
      .rst_n     (rst_n),
      .supply_ok (supply_ok),
      .ce_n      (ce_n),
      .oe_n      (oe_n),
      .we_n      (we_n),
      .wr_pulse  (wr_pulse),
      .inhibit   (inhibit)
   );

   task automatic check(input bit good, input string tag, input string what,
                        input int act, input int expv);
      checks++;
      if (!good) begin
         fails++;
         $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, expv);
      end
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   // Monitor: every pulse is matched against the front of the scoreboard.
   always @(negedge clk) begin
      if (rst_n && !done) begin
         if (prev_pulse) check(!wr_pulse, "R9", "pulse longer than one cycle", 1, 0);
         if (wr_pulse) begin
            pulse_cnt++;
            if (exp_q.size() == 0) begin
               check(1'b0, cur_tag, "unexpected pulse at cycle", cyc, -1);
            end else begin
               int e;
               e = exp_q.pop_front();
               check(cyc == e, cur_tag, "pulse cycle", cyc, e);
            end
         end
         prev_pulse = wr_pulse;
      end
   end

   // Driver helper: the strobe ended in the current cycle, so the pulse is due S+1 cycles later.
   task automatic push_expected();
      exp_q.push_back(cyc + SYNC + 1);
   endtask

   task automatic settle(input string tag, input int snap, input int nexp);
      idle(SYNC + 4);
      check(pulse_cnt - snap == nexp, tag, "pulse count", pulse_cnt - snap, nexp);
      check(exp_q.size() == 0, tag, "missing pulses", exp_q.size(), 0);
      exp_q.delete();
   endtask

   task automatic strobe(input int len, input bit accept, input string tag);
      int snap;
      snap = pulse_cnt;
      cur_tag = tag;
      @(negedge clk);
      ce_n = 1'b0; we_n = 1'b0;
      idle(len);
      ce_n = 1'b1; we_n = 1'b1;
      if (accept) push_expected();
      settle(tag, snap, accept ? 1 : 0);
   endtask

   // ce_n falls first; we_n joins; ce_n rises ending the overlap; we_n rises last.
   task automatic overlap(input int lead, input int both, input int tail,
                          input bit accept, input string tag);
      int snap;
      snap = pulse_cnt;
      cur_tag = tag;
      @(negedge clk);
      ce_n = 1'b0;
      idle(lead);
      we_n = 1'b0;
      idle(both);
      ce_n = 1'b1;
      if (accept) push_expected();
      idle(tail);
      we_n = 1'b1;
      settle(tag, snap, accept ? 1 : 0);
   endtask

   task automatic power_up(input string tag);
      @(negedge clk);
      supply_ok = 1'b1;
      idle(SYNC + HOLD - 1);
      check(inhibit == 1'b1, tag, "inhibit one cycle before hold-off end", inhibit, 1);
      idle(1);
      check(inhibit == 1'b0, tag, "inhibit at hold-off end", inhibit, 0);
   endtask

   initial begin
      int snap;
      idle(4);
      check(wr_pulse == 1'b0, "R1", "wr_pulse in reset", wr_pulse, 0);
      check(inhibit == 1'b1, "R1", "inhibit in reset", inhibit, 1);
      @(negedge clk);
      rst_n = 1'b1;
      idle(3);
      check(wr_pulse == 1'b0, "R1", "wr_pulse after reset", wr_pulse, 0);
      check(inhibit == 1'b1, "R1", "inhibit after reset", inhibit, 1);

      // R2: supply absent blocks strobes
      strobe(6, 1'b0, "R2");
      check(inhibit == 1'b1, "R2", "inhibit with supply low", inhibit, 1);

      // R3: exact hold-off length
      power_up("R3");

      // R7: width boundary
      strobe(MINW - 1, 1'b0, "R7");
      strobe(1, 1'b0, "R7");
      strobe(MINW, 1'b1, "R7");
      strobe(8, 1'b1, "R7");

      // R8: overlap of the two enables
      cur_tag = "R8";
      snap = pulse_cnt;
      @(negedge clk); ce_n = 1'b0; idle(6); ce_n = 1'b1;
      settle("R8", snap, 0);
      snap = pulse_cnt;
      @(negedge clk); we_n = 1'b0; idle(6); we_n = 1'b1;
      settle("R8", snap, 0);
      overlap(2, 4, 2, 1'b1, "R8");
      overlap(3, MINW - 1, 3, 1'b0, "R8");

      // R9: pulse cycle and width on a long strobe
      strobe(5, 1'b1, "R9");

      // R6: output enable active for one cycle in the middle of a strobe
      cur_tag = "R6";
      snap = pulse_cnt;
      @(negedge clk); ce_n = 1'b0; we_n = 1'b0;
      idle(2); oe_n = 1'b0; idle(1); oe_n = 1'b1; idle(4);
      ce_n = 1'b1; we_n = 1'b1;
      settle("R6", snap, 0);
      strobe(MINW, 1'b1, "R6");

      // R5: supply loss after hold-off
      @(negedge clk); supply_ok = 1'b0;
      idle(SYNC);
      check(inhibit == 1'b0, "R5", "inhibit S cycles after supply loss", inhibit, 0);
      idle(1);
      check(inhibit == 1'b1, "R5", "inhibit S+1 cycles after supply loss", inhibit, 1);
      strobe(6, 1'b0, "R2");

      // R4: one-cycle dropout during the hold-off restarts it
      @(negedge clk); supply_ok = 1'b1;
      idle(SYNC + HOLD / 2);
      supply_ok = 1'b0;
      idle(1);
      supply_ok = 1'b1;
      idle(SYNC + HOLD - 1);
      check(inhibit == 1'b1, "R4", "inhibit before restarted hold-off end", inhibit, 1);
      idle(1);
      check(inhibit == 1'b0, "R4", "inhibit at restarted hold-off end", inhibit, 0);
      strobe(MINW, 1'b1, "R4");

      // R5: supply lost in the middle of a strobe
      cur_tag = "R5";
      snap = pulse_cnt;
      @(negedge clk); ce_n = 1'b0; we_n = 1'b0;
      idle(2); supply_ok = 1'b0; idle(3);
      ce_n = 1'b1; we_n = 1'b1;
      settle("R5", snap, 0);

      // R10: strobe that starts inside the hold-off and ends after it
      cur_tag = "R10";
      snap = pulse_cnt;
      @(negedge clk); supply_ok = 1'b1;
      idle(SYNC + HOLD - 3);
      ce_n = 1'b0; we_n = 1'b0;
      idle(6);
      ce_n = 1'b1; we_n = 1'b1;
      settle("R10", snap, 0);
      check(inhibit == 1'b0, "R10", "inhibit after hold-off", inhibit, 0);
      strobe(MINW, 1'b1, "R10");

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         checks++;
         fails++;
         $display("FAIL %s watchdog: actual=%0d expected=%0d", cur_tag, cyc, 0);
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

endmodule